// File: doc/BRIEF.md
# Error-Detection Packet Presence and UES Flag Updater

This block watches a stream of 10-bit video words and decides, once per field, whether that field carried a valid error-detection packet. A packet counts as present only when its header appears in the stream and also lands where the video standard expects it. The expected location comes from an upstream strobe. The standard is detected elsewhere, and this block does not re-insert the packet.

From the packet's three flag words (ancillary, active picture, full field), the block derives the outgoing unknown-error-status bits. A group's outgoing bit is set when the incoming packet already reported an unknown error for that group, or when the group's validity bit was clear. When no packet is found, all three outgoing bits are set. At each field boundary the block updates a registered missing-packet flag and the three outgoing bits. Both hold steady until the next boundary.

Top module: `edh_presence_ues`

## Requirements
- R1: A header is recognised when four consecutive valid words (cycles with `word_vld_i` low are skipped) equal 0x000, 0x3FF, 0x3FF, 0x1F4 in that order.
- R2: A header counts as correctly placed only when `pos_stb_i` is high, together with `word_vld_i`, on the cycle that carries its 0x1F4 word.
- R3: On the clock edge where `field_end_i` is sampled high, `missing_o` is loaded with the NAND of "a header was seen this field" and "a header was correctly placed this field".
- R4: `missing_o` and `ues_o` change only on a field-end edge. The missing flag reflects only the field just ended, so a good field after a bad one clears it.
- R5: For a present packet, each outgoing bit equals incoming UES OR NOT incoming V. The flag words sit at valid-word offsets 9 (ancillary), 10 (active picture) and 11 (full field), counted from the 0x1F4 word as offset 0. In each flag word UES is bit 4 and V is bit 5. In `ues_o`, bit 0 is ancillary, bit 1 is active picture and bit 2 is full field.
- R6: When `missing_o` is loaded high, `ues_o` is loaded with 3'b111.
- R7: If a field ends before a group's flag word arrives, that group's outgoing bit is set.
- R8: After synchronous reset, `missing_o` is 0 and `ues_o` is 3'b000.
- R9: A header whose 0x1F4 word arrives without `pos_stb_i` leaves the packet absent for that field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_i | input | 10 | Video word |
| word_vld_i | input | 1 | Qualifies `word_i` |
| pos_stb_i | input | 1 | Expected header location for the detected standard |
| field_end_i | input | 1 | One-cycle field boundary pulse |
| missing_o | output | 1 | Packet absent in the field just ended |
| ues_o | output | 3 | Outgoing unknown-error-status bits {FF, AP, ANC} |

## Verification
Both results are due on the single clock edge that samples `field_end_i` high, and are read at the falling edge that follows it. The monitor waits for a field-end cycle, then samples at that falling edge and compares against the next queued expectation. Between boundaries the outputs must stay put, and an assertion guards that. Fields cover clean, flagged, missing, misplaced, corrupted, gapped and truncated packets.

// File: rtl/edh_pkg.sv
package edh_pkg;
  localparam int WORD_W = 10;
  localparam int NGRP   = 3;
  localparam logic [WORD_W-1:0] HDR0 = 10'h000;
  localparam logic [WORD_W-1:0] HDR1 = 10'h3FF;
  localparam logic [WORD_W-1:0] HDR2 = 10'h3FF;
  localparam logic [WORD_W-1:0] HDR3 = 10'h1F4;

  typedef struct packed {
    logic ues;
    logic v;
  } grp_flag_t;
endpackage

// File: rtl/edh_hdr_match.sv
module edh_hdr_match
  import edh_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_vld_i,
  input  logic              pos_stb_i,
  output logic              hdr_any_o,
  output logic              hdr_placed_o
);
  localparam int DEPTH = 3;

  logic [WORD_W-1:0] win_q [DEPTH];

  // window of the previous valid words; win_q[0] is the most recent
  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_win
      always_ff @(posedge clk) begin
        if (rst) begin
          win_q[i] <= '1;
        end else if (word_vld_i) begin
          if (i == 0) win_q[i] <= word_i;
          else        win_q[i] <= win_q[i-1];
        end
      end
    end
  endgenerate

  assign hdr_any_o = word_vld_i && (win_q[2] == HDR0) && (win_q[1] == HDR1)
                     && (win_q[0] == HDR2) && (word_i == HDR3);
  assign hdr_placed_o = hdr_any_o && pos_stb_i;
endmodule

// File: rtl/edh_flag_capture.sv
module edh_flag_capture
  import edh_pkg::*;
#(
  parameter int OFS_ANC = 9,
  parameter int OFS_AP  = 10,
  parameter int OFS_FF  = 11,
  parameter int UES_BIT = 4,
  parameter int V_BIT   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_vld_i,
  input  logic              field_end_i,
  input  logic              hit_i,
  output grp_flag_t         flags_o [NGRP]
);
  localparam int MAX_OFS = (OFS_ANC > OFS_AP) ?
                           ((OFS_ANC > OFS_FF) ? OFS_ANC : OFS_FF) :
                           ((OFS_AP  > OFS_FF) ? OFS_AP  : OFS_FF);
  localparam int CW = $clog2(MAX_OFS + 2);

  logic [CW-1:0] cnt_q;
  logic          act_q;

  // valid-word counter running from the placed header's last word
  always_ff @(posedge clk) begin
    if (rst || field_end_i) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (hit_i) begin
      act_q <= 1'b1;
      cnt_q <= CW'(1);
    end else if (act_q && word_vld_i) begin
      if (cnt_q == CW'(MAX_OFS)) act_q <= 1'b0;
      else                       cnt_q <= cnt_q + 1'b1;
    end
  end

  generate
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
      localparam int OFS = (g == 0) ? OFS_ANC : (g == 1) ? OFS_AP : OFS_FF;
      grp_flag_t flag_q;
      // uncaptured groups default to "unknown error" (UES set, V clear)
      always_ff @(posedge clk) begin
        if (rst || field_end_i || hit_i) begin
          flag_q <= '{ues: 1'b1, v: 1'b0};
        end else if (act_q && word_vld_i && cnt_q == CW'(OFS)) begin
          flag_q <= '{ues: word_i[UES_BIT], v: word_i[V_BIT]};
        end
      end
      assign flags_o[g] = flag_q;
    end
  endgenerate

  // R5: offset counter never runs past the last flag word
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(MAX_OFS));
  // R2: capture starts only after a correctly placed header
  a_r2_start_placed: assert property (@(posedge clk) disable iff (rst)
    $rose(act_q) |-> $past(hit_i));
endmodule

// File: rtl/edh_field_eval.sv
module edh_field_eval
  import edh_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            field_end_i,
  input  logic            hdr_any_i,
  input  logic            hdr_placed_i,
  input  grp_flag_t       flags_i [NGRP],
  output logic            missing_o,
  output logic [NGRP-1:0] ues_o
);
  logic seen_q, placed_q, present;

  assign present = seen_q && placed_q;

  always_ff @(posedge clk) begin
    if (rst || field_end_i) begin
      seen_q   <= 1'b0;
      placed_q <= 1'b0;
    end else begin
      if (hdr_any_i)    seen_q   <= 1'b1;
      if (hdr_placed_i) placed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      missing_o <= 1'b0;
    end else if (field_end_i) begin
      missing_o <= ~present;
    end
  end

  generate
    for (genvar g = 0; g < NGRP; g++) begin : g_ues
      always_ff @(posedge clk) begin
        if (rst) begin
          ues_o[g] <= 1'b0;
        end else if (field_end_i) begin
          ues_o[g] <= present ? (flags_i[g].ues | ~flags_i[g].v) : 1'b1;
        end
      end
    end
  endgenerate

  // R2: a placed header implies a header was seen
  a_r2_placed_seen: assert property (@(posedge clk) disable iff (rst)
    placed_q |-> seen_q);
  // R9: field without a placed header reports missing
  a_r9_unplaced_missing: assert property (@(posedge clk) disable iff (rst)
    (field_end_i && !placed_q) |=> missing_o);
  // R6: missing packet forces all UES bits
  a_r6_absent_all_set: assert property (@(posedge clk) disable iff (rst)
    missing_o |-> (ues_o == '1));
  // R4: outputs hold between field boundaries
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !field_end_i |=> $stable({missing_o, ues_o}));
endmodule

// File: rtl/edh_presence_ues.sv
module edh_presence_ues
  import edh_pkg::*;
#(
  parameter int OFS_ANC = 9,
  parameter int OFS_AP  = 10,
  parameter int OFS_FF  = 11,
  parameter int UES_BIT = 4,
  parameter int V_BIT   = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [9:0]  word_i,
  input  logic        word_vld_i,
  input  logic        pos_stb_i,
  input  logic        field_end_i,
  output logic        missing_o,
  output logic [2:0]  ues_o
);
  logic      hdr_any, hdr_placed;
  grp_flag_t flags [NGRP];

  edh_hdr_match u_match (
    .clk          (clk),
    .rst          (rst),
    .word_i       (word_i),
    .word_vld_i   (word_vld_i),
    .pos_stb_i    (pos_stb_i),
    .hdr_any_o    (hdr_any),
    .hdr_placed_o (hdr_placed)
  );

  edh_flag_capture #(
    .OFS_ANC (OFS_ANC),
    .OFS_AP  (OFS_AP),
    .OFS_FF  (OFS_FF),
    .UES_BIT (UES_BIT),
    .V_BIT   (V_BIT)
  ) u_cap (
    .clk         (clk),
    .rst         (rst),
    .word_i      (word_i),
    .word_vld_i  (word_vld_i),
    .field_end_i (field_end_i),
    .hit_i       (hdr_placed),
    .flags_o     (flags)
  );

  edh_field_eval u_eval (
    .clk          (clk),
    .rst          (rst),
    .field_end_i  (field_end_i),
    .hdr_any_i    (hdr_any),
    .hdr_placed_i (hdr_placed),
    .flags_i      (flags),
    .missing_o    (missing_o),
    .ues_o        (ues_o)
  );
endmodule

// File: tb/sim_edh_presence_ues.sv
module sim_edh_presence_ues;
  logic       clk = 1'b0;
  logic       rst;
  logic [9:0] word_i;
  logic       word_vld_i, pos_stb_i, field_end_i;
  logic       missing_o;
  logic [2:0] ues_o;

  always #2.5 clk = ~clk;

  edh_presence_ues u0 (
    .clk(clk), .rst(rst), .word_i(word_i), .word_vld_i(word_vld_i),
    .pos_stb_i(pos_stb_i), .field_end_i(field_end_i),
    .missing_o(missing_o), .ues_o(ues_o)
  );

  typedef struct { logic miss; logic [2:0] ues; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic put(input logic [9:0] w, input logic v, input logic s);
    @(negedge clk);
    word_i = w; word_vld_i = v; pos_stb_i = s; field_end_i = 1'b0;
  endtask

  function automatic logic [9:0] fw(input bit ues, input bit v);
    return 10'h200 | (ues ? 10'h010 : 10'h0) | (v ? 10'h020 : 10'h0);
  endfunction

  // mode: 0 placed, 1 header unplaced, 2 corrupted header at strobe, 3 no header
  task automatic field(input int mode, input logic [9:0] fa, fp, ff,
                       input int trunc, input bit gaps, input string tag);
    logic [9:0] pl[12];
    exp_t e;
    bit present;
    logic [2:0] u;
    present = (mode == 0);
    for (int k = 0; k < 12; k++) pl[k] = 10'h200;
    pl[9] = fa; pl[10] = fp; pl[11] = ff;
    for (int k = 0; k < 4; k++) put(10'h040, 1'b1, (mode == 1 && k == 3));
    if (mode != 3) begin
      put(10'h000, 1'b1, 1'b0);
      if (gaps) put(10'h3FF, 1'b0, 1'b0);
      put(10'h3FF, 1'b1, 1'b0);
      put((mode == 2) ? 10'h3FE : 10'h3FF, 1'b1, 1'b0);
      put(10'h1F4, 1'b1, (mode == 0 || mode == 2));
      for (int k = 1; k <= trunc; k++) begin
        if (gaps) put(10'h000, 1'b0, 1'b0);
        put(pl[k], 1'b1, 1'b0);
      end
    end
    for (int k = 0; k < 3; k++) put(10'h040, 1'b1, 1'b0);
    u[0] = !(present && trunc >= 9)  || fa[4] || !fa[5];
    u[1] = !(present && trunc >= 10) || fp[4] || !fp[5];
    u[2] = !(present && trunc >= 11) || ff[4] || !ff[5];
    e.miss = !present; e.ues = u; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    word_vld_i = 1'b0; pos_stb_i = 1'b0; field_end_i = 1'b1;
    put(10'h040, 1'b0, 1'b0);
    put(10'h040, 1'b0, 1'b0);
  endtask

  // monitor: results are due on the edge that samples field_end_i
  initial begin
    forever begin
      @(posedge clk);
      if (field_end_i === 1'b1) begin
        exp_t e;
        @(negedge clk);
        e = q.pop_front();
        checks++;
        if (missing_o !== e.miss) begin
          fails++;
          $display("FAIL %s missing_o actual %0b expected %0b", e.tag, missing_o, e.miss);
        end
        checks++;
        if (ues_o !== e.ues) begin
          fails++;
          $display("FAIL %s ues_o actual %03b expected %03b", e.tag, ues_o, e.ues);
        end
      end
    end
  end

  initial begin
    #(5 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; word_i = '0; word_vld_i = 0; pos_stb_i = 0; field_end_i = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (missing_o !== 1'b0 || ues_o !== 3'b000) begin
      fails++;
      $display("FAIL R8 reset actual %0b/%03b expected 0/000", missing_o, ues_o);
    end
    field(0, fw(0,1), fw(0,1), fw(0,1), 11, 0, "R1 R3 clean packet");
    field(0, fw(0,1), fw(0,0), fw(0,1), 11, 0, "R5 AP V low");
    field(0, fw(0,1), fw(0,1), fw(1,1), 11, 0, "R5 FF UES high");
    field(0, fw(1,0), fw(0,1), fw(0,1), 11, 0, "R5 ANC UES and V low");
    field(3, fw(0,1), fw(0,1), fw(0,1), 11, 0, "R6 no packet");
    field(0, fw(0,1), fw(0,1), fw(0,1), 11, 0, "R4 recovered field");
    field(1, fw(0,1), fw(0,1), fw(0,1), 11, 0, "R9 R2 unplaced header");
    field(2, fw(0,1), fw(0,1), fw(0,1), 11, 0, "R1 corrupted header");
    field(0, fw(0,1), fw(1,1), fw(0,1), 11, 1, "R1 R5 gapped stream");
    field(0, fw(0,1), fw(0,1), fw(0,1), 10, 0, "R7 truncated before FF");
    field(0, fw(0,1), fw(0,1), fw(0,1), 3, 0,  "R7 truncated before flags");
    field(0, fw(0,1), fw(0,1), fw(0,1), 11, 0, "R4 final clean");
    repeat (4) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule